// File: doc/BRIEF.md
# Parallel Bank Permutation Generator

A turbo decoder that runs many component-decoder lanes side by side splits its extrinsic memory into as many banks as there are lanes. In the interleaved half-iteration, every lane needs to know in each cycle which bank its next value sits in. This block takes one base bank number and a few small constants, and returns one bank index per lane. Together these indices form the select vector for the lane-to-bank crossbar.

The lane count is a power of two from 8 to 64. The bank index of lane `j` is the base bank number plus a per-lane offset plus a counter-dependent term, all taken modulo the lane count. Because the interleaver's quadratic coefficient is even, the counter term is always a multiple of four. It depends only on `j` modulo a quarter of the lane count. For that reason only a quarter of the lanes form a product, and every other lane reuses one of those products.

Each product is a narrow multiply modulo a quarter of the lane count. By default the output is combinational, which leaves the upstream multiply register as the only pipeline stage. A parameter can add one output register.

Top module: `bank_perm_gen`

## Requirements
- R1: Lane 0 output (bits [LW-1:0] of `lane_bank`, where LW = log2(LANES)) equals `base_bank` whenever lane 0's offset in `lane_off` is zero.
- R2: For lane j, the output in slice `lane_bank[j*LW +: LW]` equals (`base_bank` + `lane_off[j*LW +: LW]` + 4·((`f2_half`·(j mod LANES/4)·`step_lo`) mod LANES/4)) mod LANES. With valid inputs this equals floor(π(c + j·S)/S), where π(i) = (f1·i + f2·i²) mod K and S = K/LANES.
- R3: For every lane, (output − `base_bank` − own offset) mod 4 is zero.
- R4: Lanes j and j + LANES/4 carry the same counter term, so (output − offset) agrees between them modulo LANES.
- R5: When the inputs come from a valid quadratic permutation with LANES dividing K, the LANES outputs are all distinct in every cycle.
- R6: When `f2_half` is 0 or `step_lo` is 0, every lane output equals (`base_bank` + its offset) mod LANES.
- R7: With REG_OUT = 0, the outputs follow the inputs in the same cycle. With REG_OUT = 1, they show the inputs of the previous rising edge and are all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_bank | input | LW | Bank number of the first lane, floor(π(c)/S) |
| lane_off | input | LANES·LW | Per-lane constant offsets, lane j at slice j·LW |
| f2_half | input | LW−2 | (f2/2) mod (LANES/4) |
| step_lo | input | LW−2 | Counter c modulo LANES/4 |
| lane_bank | output | LANES·LW | Bank index of every lane, lane j at slice j·LW |

## Verification
The permutation property only holds if `base_bank`, `lane_off`, `f2_half` and `step_lo` all come from one consistent (K, f1, f2, c) set. That set must satisfy: K is a multiple of LANES, f2 is even, and the lane 0 offset is zero. The bench meets this by computing every input from a table of valid interleaver triples, never from free values. It changes all inputs together on the falling edge, and it loads a valid set before reset is released. The other properties (multiple-of-four residue, quarter-period reuse, and the no-term case) hold for any input values.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic bit lanes_ok(input int unsigned v);
      return is_pow2(v) && (v >= 8) && (v <= 64);
   endfunction

endpackage

// File: rtl/bpg_step_table.sv
// Forms the counter term for each residue class r = j mod (LANES/4).
// r = 0 is tied to zero, so only GROUPS-1 narrow multiplies exist.
module bpg_step_table #(
   parameter int unsigned GROUPS = 8,
   parameter int unsigned QW     = 3,
   localparam int unsigned LW    = QW + 2
) (
   input  logic [QW-1:0]        f2_half,
   input  logic [QW-1:0]        step_lo,
   output logic [GROUPS*LW-1:0] terms
);

   genvar r;
   generate
      for (r = 0; r < GROUPS; r++) begin : g_res
         if (r == 0) begin : g_zero
            assign terms[LW-1:0] = '0;
         end else begin : g_mul
            logic [QW-1:0] coef;
            logic [QW-1:0] prod;
            // coefficient (f2/2 * r) mod GROUPS, then times c mod GROUPS
            assign coef = QW'(f2_half * QW'(r));
            assign prod = QW'(coef * step_lo);
            assign terms[r*LW +: LW] = {prod, 2'b00};
         end
      end
   endgenerate

endmodule

// File: rtl/bpg_lane_add.sv
// One lane: three-input add, truncated to the bank index width (mod LANES).
module bpg_lane_add #(
   parameter int unsigned LW = 5
) (
   input  logic [LW-1:0] base_i,
   input  logic [LW-1:0] off_i,
   input  logic [LW-1:0] term_i,
   output logic [LW-1:0] sum_o
);

   assign sum_o = base_i + off_i + term_i;

endmodule

// File: rtl/bpg_out_reg.sv
module bpg_out_reg #(
   parameter int unsigned W = 160
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/bank_perm_gen.sv
module bank_perm_gen
   import bpg_pkg::*;
#(
   parameter int unsigned LANES   = 32,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned LW     = $clog2(LANES),
   localparam int unsigned QW     = LW - 2,
   localparam int unsigned GROUPS = LANES / 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LW-1:0]       base_bank,
   input  logic [LANES*LW-1:0] lane_off,
   input  logic [QW-1:0]       f2_half,
   input  logic [QW-1:0]       step_lo,
   output logic [LANES*LW-1:0] lane_bank
);

   generate
      if (!lanes_ok(LANES)) begin : g_bad_lanes
         $error("bank_perm_gen: LANES must be a power of two in 8..64");
      end
   endgenerate

   logic [GROUPS*LW-1:0] step_terms;
   logic [LANES*LW-1:0]  lane_raw;

   bpg_step_table #(
      .GROUPS (GROUPS),
      .QW     (QW)
   ) u_terms (
      .f2_half (f2_half),
      .step_lo (step_lo),
      .terms   (step_terms)
   );

   genvar j;
   generate
      for (j = 0; j < LANES; j++) begin : g_lane
         // lanes at and above GROUPS reuse the term of lane j mod GROUPS
         bpg_lane_add #(.LW(LW)) u_add (
            .base_i (base_bank),
            .off_i  (lane_off[j*LW +: LW]),
            .term_i (step_terms[(j % GROUPS)*LW +: LW]),
            .sum_o  (lane_raw[j*LW +: LW])
         );
      end

      if (REG_OUT) begin : g_reg
         bpg_out_reg #(.W(LANES*LW)) u_oreg (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (lane_raw),
            .q     (lane_bank)
         );
      end else begin : g_comb
         assign lane_bank = lane_raw;
      end
   endgenerate

endmodule

// File: rtl/bpg_check.sv
module bpg_check #(
   parameter int unsigned LANES   = 32,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned LW     = $clog2(LANES),
   localparam int unsigned QW     = LW - 2,
   localparam int unsigned GROUPS = LANES / 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [LW-1:0]       base_bank,
   input logic [LANES*LW-1:0] lane_off,
   input logic [QW-1:0]       f2_half,
   input logic [QW-1:0]       step_lo,
   input logic [LANES*LW-1:0] lane_bank
);

   logic                armed;
   logic [LW-1:0]       r_base;
   logic [LANES*LW-1:0] r_off;
   logic [QW-1:0]       r_f2;
   logic [QW-1:0]       r_step;

   generate
      if (REG_OUT) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed  <= 1'b0;
               r_base <= '0;
               r_off  <= '0;
               r_f2   <= '0;
               r_step <= '0;
            end else begin
               armed  <= 1'b1;
               r_base <= base_bank;
               r_off  <= lane_off;
               r_f2   <= f2_half;
               r_step <= step_lo;
            end
         end
      end else begin : g_now
         always_comb begin
            armed  = 1'b1;
            r_base = base_bank;
            r_off  = lane_off;
            r_f2   = f2_half;
            r_step = step_lo;
         end
      end
   endgenerate

   logic [LANES-1:0] seen;
   logic [LW-1:0]    resid [LANES];
   logic             quad_ok, period_ok, zero_ok;

   always_comb begin
      seen      = '0;
      quad_ok   = 1'b1;
      period_ok = 1'b1;
      zero_ok   = 1'b1;
      for (int j = 0; j < LANES; j++) begin
         resid[j] = lane_bank[j*LW +: LW] - r_base - r_off[j*LW +: LW];
         seen[lane_bank[j*LW +: LW]] = 1'b1;
         if (resid[j][1:0] != 2'b00) quad_ok = 1'b0;
         if (resid[j] != '0) zero_ok = 1'b0;
      end
      for (int j = GROUPS; j < LANES; j++) begin
         if (resid[j] != resid[j-GROUPS]) period_ok = 1'b0;
      end
   end

   p_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (r_off[LW-1:0] == '0)) |-> (lane_bank[LW-1:0] == r_base));

   p_quad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> quad_ok);

   p_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> period_ok);

   p_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (&seen));

   p_noterm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ((r_f2 == '0) || (r_step == '0))) |-> zero_ok);

endmodule

bind bank_perm_gen bpg_check #(.LANES(LANES), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bank_perm_gen_test.sv
`timescale 1ns/1ps
module bank_perm_gen_test;
   localparam int unsigned LANES = 32;
   localparam int unsigned LW    = 5;
   localparam int unsigned QW    = 3;
   localparam int unsigned Q     = 8;
   localparam int NVEC = 8;
   // rows: K, f1, f2 (valid quadratic permutations, K multiple of 32)
   localparam int unsigned TBL [NVEC][3] = '{
      '{256, 15, 32}, '{512, 31, 64}, '{1024, 31, 64}, '{2048, 31, 64},
      '{6144, 263, 480}, '{1536, 71, 204}, '{4096, 31, 128}, '{3072, 97, 96}};

   logic clk = 1'b0;
   always #4 clk = ~clk;
   logic rst_n = 1'b0;

   logic [LW-1:0]       base;
   logic [LANES*LW-1:0] off;
   logic [QW-1:0]       f2h, stp;
   logic [LANES*LW-1:0] out_c, out_r;

   bank_perm_gen #(.LANES(LANES), .REG_OUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .base_bank(base), .lane_off(off),
      .f2_half(f2h), .step_lo(stp), .lane_bank(out_c));

   bank_perm_gen #(.LANES(LANES), .REG_OUT(1'b1)) uut_reg (
      .clk(clk), .rst_n(rst_n), .base_bank(base), .lane_off(off),
      .f2_half(f2h), .step_lo(stp), .lane_bank(out_r));

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   int exp_b [LANES];
   int c1    [LANES];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic longint qpp(input longint k, input longint f1,
                                  input longint f2, input longint i);
      return (f1 * i + f2 * i * i) % k;
   endfunction

   task automatic load(input int k, input int f1, input int f2, input int c);
      int s;
      s = k / LANES;
      for (int j = 0; j < LANES; j++) begin
         c1[j] = int'((longint'(f1) * j + longint'(f2) * j * j * s) % LANES);
         off[j*LW +: LW] = LW'(c1[j]);
         exp_b[j] = int'(qpp(k, f1, f2, c + j * s) / s);
      end
      base = LW'(exp_b[0]);
      f2h  = QW'((f2 / 2) % Q);
      stp  = QW'(c % Q);
   endtask

   task automatic check_comb();
      logic [LANES-1:0] seen;
      int act, act0;
      seen = '0;
      chk(out_c[LW-1:0] == base, "R1 lane0 equals base", int'(out_c[LW-1:0]), int'(base));
      for (int j = 0; j < LANES; j++) begin
         act = int'(out_c[j*LW +: LW]);
         seen[act] = 1'b1;
         chk(act == exp_b[j], "R2 lane vs direct floor(pi/S)", act, exp_b[j]);
         chk(((act - int'(base) - c1[j]) & 3) == 0, "R3 term multiple of 4",
             (act - int'(base) - c1[j]) & 3, 0);
         if (j >= Q) begin
            act0 = int'(out_c[(j-Q)*LW +: LW]);
            chk(((act - c1[j]) & (LANES-1)) == ((act0 - c1[j-Q]) & (LANES-1)),
                "R4 quarter-period term reuse", (act - c1[j]) & (LANES-1),
                (act0 - c1[j-Q]) & (LANES-1));
         end
         if (f2h == '0 || stp == '0)
            chk(act == ((int'(base) + c1[j]) % LANES), "R6 no counter term",
                act, (int'(base) + c1[j]) % LANES);
      end
      chk(&seen, "R5 outputs form a permutation", $countones(seen), LANES);
   endtask

   initial begin
      load(256, 15, 32, 0);
      repeat (3) @(posedge clk);
      #1;
      chk(out_r == '0, "R7 registered output zero in reset", $countones(out_r), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < NVEC; t++) begin
         for (int c = 0; c < int'(TBL[t][0] / LANES); c++) begin
            @(negedge clk);
            load(int'(TBL[t][0]), int'(TBL[t][1]), int'(TBL[t][2]), c);
            #1;
            // no clock edge since the inputs changed: same-cycle path (R7)
            check_comb();
            @(posedge clk);
            #1;
            for (int j = 0; j < LANES; j++)
               chk(int'(out_r[j*LW +: LW]) == exp_b[j], "R7 registered one-cycle delay",
                   int'(out_r[j*LW +: LW]), exp_b[j]);
         end
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1600000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule